// File: doc/BRIEF.md
# Linked-Descriptor Multi-Lane SPI Transfer Engine

This block moves data between word-addressed memory and a SPI flash-style device without processor help. Software fills a chain of four-word descriptors in memory, loads the address of the first into a base register, and writes a start code into the control register. The engine then fetches each descriptor in turn. It runs a half-duplex transfer on one, two or four data lanes, as that descriptor selects, and stores received bytes or sends stored bytes through a simple request/acknowledge memory port. It follows the next pointer until it reaches a descriptor flagged as the end of the list.

Each descriptor carries its own settings: byte count, direction, lane width, bit order, device select, and whether to drop chip select afterwards. After a descriptor finishes, the engine returns it to software by writing its control word back with the hardware-ownership bit cleared. It can pulse a per-descriptor event, a packet-complete event and an error event. The serial clock is paced by a strobe from an external clock divider.

Top module: `qce_top`

## Requirements
- R1: A descriptor at byte address A holds control at A, status at A+4 (never read), buffer address at A+8 and next-descriptor address at A+12. Writing the control register (reg_sel=0) with bits 2:0 all set while idle starts processing at the address last written to the base register (reg_sel=1).
- R2: Control bits 8:0 give the byte count (0 to 256). Bytes sit little-endian in 32-bit buffer words, with byte 0 in bits 7:0.
- R3: Control bit 23 selects four lanes (io[3:0]) and bit 22 selects two lanes (io[1:0]). Bit 23 wins if both are set. With neither set a single lane is used: transmit on io[0], receive on io[1].
- R4: Bits go out and come in most-significant first, and within a clock the higher-numbered lane carries the more significant bit. Control bit 25 reverses the bit order of every byte.
- R5: Control bit 20 makes the descriptor receive-only: io_oe stays 0 and the bytes are written to the buffer, with unused upper bytes of a final partial word written as zero. Otherwise the descriptor only transmits.
- R6: Control bits 29:28 (bit 28 alone when two selects exist) choose the active-low cs_n line, and at most one is low. Chip select stays low across chained descriptors until one with control bit 30 set has finished.
- R7: After each descriptor's data, the engine writes its control word back to address A with bit 31 cleared.
- R8: evt_bd_done pulses for one cycle after a descriptor with control bit 16 set completes.
- R9: A descriptor with control bit 19 set ends processing. evt_pkt_done then pulses once if its bit 17 is set.
- R10: A fetched control word with bit 31 clear raises evt_err, releases chip select and stops, with no serial clocks and no write-back.
- R11: A descriptor not marked last whose next address is zero raises evt_err after its write-back, releases chip select and stops.
- R12: Writing zero to the control register halts at once: chip select released, sck low, io_oe zero, and no further events or clocks.
- R13: SPI mode 0: sck idles low, and each sck_tick during a byte toggles it. Input is sampled at the rising edge and output shifts after the falling edge, taking 8/lanes clocks per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = base address register |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| sck_tick | input | 1 | Serial clock toggle strobe from the clock divider |
| sck | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data lane outputs |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane inputs |
| evt_bd_done | output | 1 | Descriptor-complete pulse |
| evt_pkt_done | output | 1 | Packet-complete pulse |
| evt_err | output | 1 | Error pulse |

## Verification
The request-hold property assumes the memory side answers each request with a single-cycle acknowledge and that the request may be withdrawn only by a halt. The bench memory model acknowledges one cycle after it sees a request and then lowers the acknowledge. The properties also assume that sck_tick is the only thing that moves the serial clock and that the bus is not driven while receiving. The bench device model changes io_in only after an observed rising sck edge, so every sampled bit is known in advance. The stimulus writes the start code only while the engine is idle, and every descriptor chain it builds has legal lengths.

// File: rtl/qce_pkg.sv
package qce_pkg;
   typedef enum logic [1:0] {LN_ONE = 2'd0, LN_TWO = 2'd1, LN_FOUR = 2'd2} lane_e;

   localparam int F_BD_EVT  = 16;
   localparam int F_PKT_EVT = 17;
   localparam int F_END     = 19;
   localparam int F_RX      = 20;
   localparam int F_DUAL    = 22;
   localparam int F_QUAD    = 23;
   localparam int F_LSB     = 25;
   localparam int F_SEL     = 28;
   localparam int F_DROP_CS = 30;
   localparam int F_OWN     = 31;

   function automatic logic [7:0] rev8(input logic [7:0] b);
      for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
   endfunction

   function automatic logic [3:0] beats(input lane_e l);
      case (l)
         LN_TWO:  beats = 4'd4;
         LN_FOUR: beats = 4'd2;
         default: beats = 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/qce_lane_shifter.sv
module qce_lane_shifter
   import qce_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       tick,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  lane_e      lane,
   input  logic       rx_mode,
   input  logic       lsb_first,
   input  logic [3:0] io_in,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sck,
   output logic [3:0] io_out,
   output logic [3:0] io_oe
);
   logic [7:0] sh_q, sh_in, sh_out;
   logic [3:0] cnt_q;
   logic       sck_q, busy_q, done_q;

   always_comb begin
      case (lane)
         LN_TWO:  begin sh_in = {sh_q[5:0], io_in[1:0]}; sh_out = {sh_q[5:0], 2'b00}; end
         LN_FOUR: begin sh_in = {sh_q[3:0], io_in[3:0]}; sh_out = {sh_q[3:0], 4'b0000}; end
         default: begin sh_in = {sh_q[6:0], io_in[1]};   sh_out = {sh_q[6:0], 1'b0}; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0; cnt_q <= '0; sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
         end else if (start && !busy_q) begin
            sh_q   <= lsb_first ? rev8(tx_byte) : tx_byte;
            cnt_q  <= beats(lane);
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
         end else if (busy_q && tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               cnt_q <= cnt_q - 4'd1;
               if (rx_mode) sh_q <= sh_in;
            end else begin
               sck_q <= 1'b0;
               if (!rx_mode) sh_q <= sh_out;
               if (cnt_q == 4'd0) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      io_out = 4'b0000;
      io_oe  = 4'b0000;
      if (busy_q && !rx_mode) begin
         case (lane)
            LN_TWO:  begin io_out = {2'b00, sh_q[7:6]}; io_oe = 4'b0011; end
            LN_FOUR: begin io_out = sh_q[7:4];          io_oe = 4'b1111; end
            default: begin io_out = {3'b000, sh_q[7]};  io_oe = 4'b0001; end
         endcase
      end
   end

   assign done    = done_q;
   assign sck     = sck_q;
   assign rx_byte = lsb_first ? rev8(sh_q) : sh_q;

   AST_SCK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      sck_q |-> busy_q);                                                  // R13
   AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!sck_q && $past(sck_q)));                               // R13
   AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= 4'd8));                                        // R13
endmodule

// File: rtl/qce_sequencer.sv
module qce_sequencer
   import qce_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              sh_start,
   output logic              sh_abort,
   output logic [7:0]        sh_tx_byte,
   output lane_e             sh_lane,
   output logic              sh_rx,
   output logic              sh_lsb,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx_byte,
   output logic              cs_on,
   output logic [SEL_W-1:0]  cs_sel,
   output logic              evt_bd,
   output logic              evt_pkt,
   output logic              evt_err
);
   typedef enum logic [3:0] {
      S_IDLE, S_RD_CTL, S_RD_BUF, S_RD_NXT, S_PREP, S_RD_WORD,
      S_SHIFT, S_WAIT, S_WR_WORD, S_WB, S_FINISH
   } st_e;

   st_e               st_q;
   logic [ADDR_W-1:0] base_q, cur_q, buf_q, nxt_q;
   logic [31:0]       ctl_q, word_q;
   logic [8:0]        remain_q;
   logic [1:0]        bidx_q;
   logic              cs_on_q, bd_q, pkt_q, err_q;
   logic [SEL_W-1:0]  sel_q;
   logic              halt, go;

   assign halt = reg_wr && !reg_sel && (reg_wdata == 32'h0);
   assign go   = reg_wr && !reg_sel && (reg_wdata[2:0] == 3'b111) && (st_q == S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; base_q <= '0; cur_q <= '0; buf_q <= '0; nxt_q <= '0;
         ctl_q <= '0; word_q <= '0; remain_q <= '0; bidx_q <= '0;
         cs_on_q <= 1'b0; sel_q <= '0; bd_q <= 1'b0; pkt_q <= 1'b0; err_q <= 1'b0;
      end else begin
         bd_q <= 1'b0; pkt_q <= 1'b0; err_q <= 1'b0;
         if (reg_wr && reg_sel) base_q <= reg_wdata[ADDR_W-1:0];
         if (halt) begin
            st_q    <= S_IDLE;
            cs_on_q <= 1'b0;
         end else begin
            case (st_q)
               S_IDLE: if (go) begin
                  cur_q <= base_q;
                  st_q  <= S_RD_CTL;
               end
               S_RD_CTL: if (mem_ack) begin
                  ctl_q <= mem_rdata;
                  if (!mem_rdata[F_OWN]) begin
                     err_q   <= 1'b1;
                     cs_on_q <= 1'b0;
                     st_q    <= S_IDLE;
                  end else st_q <= S_RD_BUF;
               end
               S_RD_BUF: if (mem_ack) begin
                  buf_q <= mem_rdata[ADDR_W-1:0];
                  st_q  <= S_RD_NXT;
               end
               S_RD_NXT: if (mem_ack) begin
                  nxt_q    <= mem_rdata[ADDR_W-1:0];
                  remain_q <= ctl_q[8:0];
                  bidx_q   <= 2'd0;
                  sel_q    <= ctl_q[F_SEL +: SEL_W];
                  cs_on_q  <= 1'b1;
                  st_q     <= S_PREP;
               end
               S_PREP: begin
                  if (remain_q == 9'd0)                   st_q <= S_WB;
                  else if (ctl_q[F_RX] || bidx_q != 2'd0) st_q <= S_SHIFT;
                  else                                    st_q <= S_RD_WORD;
               end
               S_RD_WORD: if (mem_ack) begin
                  word_q <= mem_rdata;
                  st_q   <= S_SHIFT;
               end
               S_SHIFT: st_q <= S_WAIT;
               S_WAIT: if (sh_done) begin
                  remain_q <= remain_q - 9'd1;
                  bidx_q   <= bidx_q + 2'd1;
                  if (ctl_q[F_RX]) begin
                     if (bidx_q == 2'd0) word_q <= {24'h0, sh_rx_byte};
                     else                word_q[{bidx_q, 3'b000} +: 8] <= sh_rx_byte;
                     st_q <= (bidx_q == 2'd3 || remain_q == 9'd1) ? S_WR_WORD : S_PREP;
                  end else begin
                     if (bidx_q == 2'd3) buf_q <= buf_q + ADDR_W'(4);
                     st_q <= S_PREP;
                  end
               end
               S_WR_WORD: if (mem_ack) begin
                  buf_q <= buf_q + ADDR_W'(4);
                  st_q  <= S_PREP;
               end
               S_WB: if (mem_ack) st_q <= S_FINISH;
               S_FINISH: begin
                  bd_q <= ctl_q[F_BD_EVT];
                  if (ctl_q[F_DROP_CS]) cs_on_q <= 1'b0;
                  if (ctl_q[F_END]) begin
                     pkt_q <= ctl_q[F_PKT_EVT];
                     st_q  <= S_IDLE;
                  end else if (nxt_q == '0) begin
                     err_q   <= 1'b1;
                     cs_on_q <= 1'b0;
                     st_q    <= S_IDLE;
                  end else begin
                     cur_q <= nxt_q;
                     st_q  <= S_RD_CTL;
                  end
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = word_q;
      case (st_q)
         S_RD_CTL:  mem_req = 1'b1;
         S_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(8); end
         S_RD_NXT:  begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(12); end
         S_RD_WORD: begin mem_req = 1'b1; mem_addr = buf_q; end
         S_WR_WORD: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = buf_q; end
         S_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {1'b0, ctl_q[30:0]};
         end
         default: ;
      endcase
   end

   assign sh_start   = (st_q == S_SHIFT);
   assign sh_abort   = halt;
   assign sh_tx_byte = word_q[{bidx_q, 3'b000} +: 8];
   assign sh_lane    = ctl_q[F_QUAD] ? LN_FOUR : (ctl_q[F_DUAL] ? LN_TWO : LN_ONE);
   assign sh_rx      = ctl_q[F_RX];
   assign sh_lsb     = ctl_q[F_LSB];
   assign cs_on      = cs_on_q;
   assign cs_sel     = sel_q;
   assign evt_bd     = bd_q;
   assign evt_pkt    = pkt_q;
   assign evt_err    = err_q;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr)));   // R1
   AST_ERR_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !cs_on_q);                                                // R10
   AST_PKT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_q |-> (st_q == S_IDLE));                                        // R9
   AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (!mem_req && !cs_on_q && !bd_q && !pkt_q && !err_q));      // R12
endmodule

// File: rtl/qce_top.sv
module qce_top
   import qce_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NUM_CS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              sck_tick,
   output logic              sck,
   output logic [NUM_CS-1:0] cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in,
   output logic              evt_bd_done,
   output logic              evt_pkt_done,
   output logic              evt_err
);
   localparam int SEL_W = (NUM_CS == 4) ? 2 : 1;

   if (NUM_CS != 2 && NUM_CS != 4) begin : g_bad_cs
      $error("qce_top: NUM_CS must be 2 or 4");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("qce_top: ADDR_W must lie in 8..32");
   end

   logic             s_start, s_abort, s_rx, s_lsb, s_done, s_cs_on;
   logic [7:0]       s_tx, s_rxb;
   lane_e            s_lane;
   logic [SEL_W-1:0] s_sel;

   qce_sequencer #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .sh_start(s_start), .sh_abort(s_abort), .sh_tx_byte(s_tx), .sh_lane(s_lane),
      .sh_rx(s_rx), .sh_lsb(s_lsb), .sh_done(s_done), .sh_rx_byte(s_rxb),
      .cs_on(s_cs_on), .cs_sel(s_sel),
      .evt_bd(evt_bd_done), .evt_pkt(evt_pkt_done), .evt_err(evt_err)
   );

   qce_lane_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .abort(s_abort), .tick(sck_tick), .start(s_start),
      .tx_byte(s_tx), .lane(s_lane), .rx_mode(s_rx), .lsb_first(s_lsb), .io_in(io_in),
      .done(s_done), .rx_byte(s_rxb), .sck(sck), .io_out(io_out), .io_oe(io_oe)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(s_cs_on && (s_sel == SEL_W'(i)));
   end

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));                                                   // R6
   AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> (io_oe == 4'b0000 && !sck));                            // R12
   AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe != 4'b0000) |-> !s_rx);                                      // R5
   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_pkt_done && evt_err));                                        // R9
endmodule

// File: tb/qce_top_tb.sv
module qce_top_tb;
   localparam logic [31:0] OWN = 32'h8000_0000, DROP = 32'h4000_0000, SEL1 = 32'h1000_0000;
   localparam logic [31:0] LSB = 32'h0200_0000, QUAD = 32'h0080_0000, DUAL = 32'h0040_0000;
   localparam logic [31:0] RX  = 32'h0010_0000, LAST = 32'h0008_0000;
   localparam logic [31:0] PKT = 32'h0002_0000, BDE = 32'h0001_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        sck_tick = 1'b0, sck;
   logic [1:0]  cs_n;
   logic [3:0]  io_out, io_oe, io_in = '0;
   logic        evt_bd_done, evt_pkt_done, evt_err;

   logic [31:0] mem [0:255];
   logic [3:0]  cap [0:1023];
   int          ecnt, bd_cnt, pkt_cnt, err_cnt, cs_rise;
   logic [1:0]  cs_seen, prev_cs;
   logic [3:0]  oe_or;
   logic        prev_sck;
   int          n_chk = 0, n_fail = 0;
   bit          running = 1'b1;

   always #4 clk = ~clk;

   qce_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sck_tick(sck_tick), .sck(sck),
      .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
      .evt_bd_done(evt_bd_done), .evt_pkt_done(evt_pkt_done), .evt_err(evt_err)
   );

   function automatic logic [3:0] devpat(input int k);
      return 4'((k * 7 + 5) & 15);
   endfunction

   function automatic logic [7:0] rev(input logic [7:0] b);
      for (int i = 0; i < 8; i++) rev[i] = b[7-i];
   endfunction

   // Expected byte from device pattern (dev=1) or from captured output lanes (dev=0)
   function automatic logic [7:0] build(input int k0, input int l, input bit lsb, input bit dev);
      logic [7:0] s = '0;
      for (int g = 0; g < 8 / l; g++) begin
         logic [3:0] v = dev ? devpat(k0 + g) : cap[(k0 + g) % 1024];
         if (l == 1)      s = {s[6:0], dev ? v[1] : v[0]};
         else if (l == 2) s = {s[5:0], v[1:0]};
         else             s = {s[3:0], v[3:0]};
      end
      return lsb ? rev(s) : s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // sck tick generator, memory model, device model and monitors
   initial forever begin
      @(negedge clk);
      sck_tick = ~sck_tick;
   end

   initial forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
         if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
         else        mem_rdata = mem[mem_addr[9:2]];
         mem_ack = 1'b1;
      end else mem_ack = 1'b0;
   end

   initial begin
      prev_sck = 1'b0; prev_cs = 2'b11;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (sck && !prev_sck) begin
               cap[ecnt % 1024] = io_out & io_oe;
               ecnt++;
               io_in = devpat(ecnt);
            end
            oe_or   |= io_oe;
            cs_seen |= ~cs_n;
            if (cs_n[0] && !prev_cs[0]) cs_rise++;
            if (cs_n[1] && !prev_cs[1]) cs_rise++;
            bd_cnt  += int'(evt_bd_done);
            pkt_cnt += int'(evt_pkt_done);
            err_cnt += int'(evt_err);
         end
         prev_sck = sck; prev_cs = cs_n;
      end
   end

   task automatic clear_obs();
      ecnt = 0; io_in = devpat(0); bd_cnt = 0; pkt_cnt = 0; err_cnt = 0;
      cs_rise = 0; cs_seen = 2'b00; oe_or = 4'b0000;
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic mk_desc(input int w, input logic [31:0] c, input logic [31:0] b, input logic [31:0] n);
      mem[w] = c; mem[w+1] = 32'h0; mem[w+2] = b; mem[w+3] = n;
   endtask

   task automatic run(input int w, input string req);
      int t = 0;
      clear_obs();
      wr_reg(1'b1, 32'(w * 4));
      wr_reg(1'b0, 32'h7);
      while (pkt_cnt + err_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
      if (t >= 20000) chk({req, " completion timeout"}, 32'h0, 32'h1);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R6 cs released at reset", 32'(cs_n), 32'h3);
      chk("R12 lanes idle at reset", 32'(io_oe), 32'h0);
      chk("R13 sck low at reset", 32'(sck), 32'h0);
      chk("R1 no request at reset", 32'(mem_req), 32'h0);
   endtask

   task automatic t_single_tx_chain();
      mem[128] = 32'h4433_2211; mem[129] = 32'h0000_0055; mem[144] = 32'h00CC_BBAA;
      mk_desc(0, OWN | BDE | 32'd5, 32'h200, 32'h10);
      mk_desc(4, OWN | LAST | PKT | DROP | BDE | 32'd3, 32'h240, 32'h0);
      run(0, "R9");
      begin
         logic [7:0] e [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hAA, 8'hBB, 8'hCC};
         for (int j = 0; j < 8; j++) chk("R2 R4 single-lane msb byte", 32'(build(j * 8, 1, 0, 0)), 32'(e[j]));
      end
      chk("R13 eight clocks per byte", 32'(ecnt), 32'd64);
      chk("R3 single lane drives io0 only", 32'(oe_or), 32'h1);
      chk("R6 cs held across chain", 32'(cs_rise), 32'd1);
      chk("R8 per-descriptor events", 32'(bd_cnt), 32'd2);
      chk("R9 one packet event", 32'(pkt_cnt), 32'd1);
      chk("R7 write-back first", mem[0], BDE | 32'd5);
      chk("R7 write-back second", mem[4], LAST | PKT | DROP | BDE | 32'd3);
   endtask

   task automatic t_quad_rx_lsb();
      logic [7:0] b [6];
      mem[160] = '1; mem[161] = '1;
      mk_desc(8, OWN | LAST | PKT | DROP | RX | QUAD | LSB | SEL1 | 32'd6, 32'h280, 32'h0);
      run(8, "R5");
      for (int j = 0; j < 6; j++) b[j] = build(j * 2, 4, 1, 1);
      chk("R5 R4 quad rx lsb word0", mem[160], {b[3], b[2], b[1], b[0]});
      chk("R5 partial word zero-filled", mem[161], {16'h0, b[5], b[4]});
      chk("R5 no drive while receiving", 32'(oe_or), 32'h0);
      chk("R6 select 1 used", 32'(cs_seen), 32'h2);
      chk("R8 no bd event when flag clear", 32'(bd_cnt), 32'd0);
      chk("R13 two clocks per quad byte", 32'(ecnt), 32'd12);
   endtask

   task automatic t_single_rx();
      mem[200] = '1;
      mk_desc(12, OWN | LAST | PKT | DROP | RX | 32'd2, 32'h320, 32'h0);
      run(12, "R3");
      chk("R3 single-lane rx on io1", mem[200], {16'h0, build(8, 1, 0, 1), build(0, 1, 0, 1)});
   endtask

   task automatic t_dual_tx();
      mem[176] = 32'h0000_C3A5;
      mk_desc(16, OWN | LAST | PKT | DROP | DUAL | 32'd2, 32'h2C0, 32'h0);
      run(16, "R3");
      chk("R3 dual lanes", 32'(oe_or), 32'h3);
      chk("R4 dual byte0", 32'(build(0, 2, 0, 0)), 32'hA5);
      chk("R4 dual byte1", 32'(build(4, 2, 0, 0)), 32'hC3);
   endtask

   task automatic t_quad_wins_lsb();
      mem[180] = 32'h0000_00B1;
      mk_desc(20, OWN | LAST | PKT | DROP | DUAL | QUAD | LSB | 32'd1, 32'h2D0, 32'h0);
      run(20, "R3");
      chk("R3 quad wins over dual", 32'(oe_or), 32'hF);
      chk("R4 lsb-first quad tx", 32'(build(0, 4, 1, 0)), 32'hB1);
   endtask

   task automatic t_not_owned();
      mk_desc(24, LAST | PKT | 32'd4, 32'h200, 32'h0);
      run(24, "R10");
      chk("R10 error event", 32'(err_cnt), 32'd1);
      chk("R10 no clocks", 32'(ecnt), 32'd0);
      chk("R10 cs never asserted", 32'(cs_seen), 32'h0);
      chk("R10 no write-back", mem[24], LAST | PKT | 32'd4);
   endtask

   task automatic t_null_next();
      mem[184] = 32'h0000_005A;
      mk_desc(28, OWN | 32'd1, 32'h2E0, 32'h0);
      run(28, "R11");
      chk("R11 error event", 32'(err_cnt), 32'd1);
      chk("R11 no packet event", 32'(pkt_cnt), 32'd0);
      chk("R11 write-back before error", mem[28], 32'd1);
      chk("R11 cs released", 32'(cs_n), 32'h3);
   endtask

   task automatic t_drop_mid_chain();
      mk_desc(32, OWN | DROP | 32'd1, 32'h2E0, 32'h90);
      mk_desc(36, OWN | LAST | PKT | DROP | 32'd1, 32'h2E0, 32'h0);
      run(32, "R6");
      chk("R6 cs released between descriptors", 32'(cs_rise), 32'd2);
   endtask

   task automatic t_halt();
      int e0;
      mk_desc(40, OWN | LAST | PKT | DROP | 32'd256, 32'h200, 32'h0);
      clear_obs();
      wr_reg(1'b1, 32'hA0);
      wr_reg(1'b0, 32'h7);
      repeat (300) @(negedge clk);
      wr_reg(1'b0, 32'h0);
      repeat (20) @(negedge clk);
      e0 = ecnt;
      chk("R12 cs released on halt", 32'(cs_n), 32'h3);
      chk("R12 sck low on halt", 32'(sck), 32'h0);
      chk("R12 lanes off on halt", 32'(io_oe), 32'h0);
      repeat (200) @(negedge clk);
      chk("R12 no clocks after halt", 32'(ecnt), 32'(e0));
      chk("R12 no events after halt", 32'(pkt_cnt + err_cnt + bd_cnt), 32'd0);
      chk("R12 halted before write-back", mem[40], OWN | LAST | PKT | DROP | 32'd256);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      clear_obs();
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_tx_chain();
      t_quad_rx_lsb();
      t_single_rx();
      t_dual_tx();
      t_quad_wins_lsb();
      t_not_owned();
      t_null_next();
      t_drop_mid_chain();
      t_halt();
      running = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (running) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule